// File: doc/BRIEF.md
# Collapsing store write buffer

This block sits between a processor's store path and a simple external write bus. It gathers stores into two line-sized entries. Each entry covers one aligned 16-byte line and keeps a valid flag per byte. A store that lands in a line already held by an entry that has not begun draining is folded into that entry, byte by byte. Any other store takes the next free entry. Entries leave the buffer oldest-first. Each entry goes out as a run of 32-bit word writes over a request/acknowledge handshake, and only the words that hold at least one valid byte are sent.

The bus side has separate one-way 32-bit address and data outputs plus a 4-bit byte-enable. All four bus outputs come straight from flip-flops. The store side sees a combinational stall while the buffer cannot take the offered store. A flush input is held high by the requester until the empty output rises. While flush is high, no store is taken.

Top module: `store_wbuf`

## Requirements
- R1: While reset is high, and in the first cycle after it, bus_req is low, wb_empty is high and st_stall is low.
- R2: A store whose address bits [31:4] match an entry that has not begun draining is merged into that entry. Only the byte lanes whose st_be bit is set are written: lane i is st_data[8i+7:8i]. A later store to a byte wins over an earlier one.
- R3: An entry issues only the words that have at least one valid byte, in ascending word order. bus_addr is the line address with bits [3:2] set to the word index and bits [1:0] zero. bus_be bit i is set exactly when byte lane i of that word is valid.
- R4: Entries drain in the order they were allocated. After the last word of one entry, bus_req is low for at least one cycle before the next entry's first word appears.
- R5: While bus_req is high and bus_ack is low, bus_req, bus_addr, bus_wdata and bus_be hold their values. In the cycle after a cycle with both high, the same entry's next word is on the bus, or bus_req is low.
- R6: Once an entry's first word has been presented, a store to that entry's line goes into a new entry. That new entry is written to the bus after the draining one, as separate words.
- R7: st_stall is high exactly when st_valid is high and either flush is high, or both entries are occupied, the store has a nonzero st_be and it matches no entry that is still open. A store that is stalled is not taken.
- R8: An entry frees at the clock edge that completes the acknowledge of its last word. From the next cycle, wb_empty (if no other entry is held) and the release of a stall are visible.
- R9: With the bus idle, a newly allocated oldest entry puts its first word on the bus after the second clock edge from the edge that accepted the store. A store that merges into that entry in the cycle the drain would begin pushes the first word back by one cycle.
- R10: While flush is high, every offered store is stalled and the held entries keep draining until wb_empty rises.
- R11: A store with st_be all zero is accepted without stalling and leaves no trace on the bus or in the entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store is offered |
| st_addr | input | 32 | Byte address of the store |
| st_data | input | 32 | Store data, byte lane i in bits [8i+7:8i] |
| st_be | input | 4 | Byte enables of the store |
| st_stall | output | 1 | The offered store is not taken this cycle |
| flush | input | 1 | Drain request, held until wb_empty is high |
| wb_empty | output | 1 | No entry is held |
| bus_req | output | 1 | A word write is presented (registered) |
| bus_addr | output | 32 | Word-aligned write address (registered) |
| bus_wdata | output | 32 | Write data (registered) |
| bus_be | output | 4 | Write byte enables (registered) |
| bus_ack | input | 1 | The presented word is taken at this edge |

## Verification
The assertions assume two things about the environment. First, the store source keeps a stalled store on the inputs until it is taken. Second, flush stays high until the buffer reports empty. They place no limit on when bus_ack arrives, so bus_ack may stay low for any number of cycles. The bench's bus responder only raises bus_ack after it has seen bus_req high at the falling edge, and drops it again unless a new word is waiting. The store tasks hold address, data and enables steady through every stalled cycle, and the flush scenario keeps flush high until the empty output rises.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LINE_BYTES = 16;
    localparam int N_ENT      = 2;

    localparam int BE_W      = DATA_W / 8;
    localparam int WORDS     = LINE_BYTES / BE_W;
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int LANE_W    = $clog2(BE_W);
    localparam int WIDX_W    = OFF_W - LANE_W;
    localparam int TAG_W     = ADDR_W - OFF_W;
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int HPTR_W    = $clog2(N_ENT);

    typedef logic [ADDR_W-1:0]     addr_t;
    typedef logic [DATA_W-1:0]     data_t;
    typedef logic [BE_W-1:0]       be_t;
    typedef logic [TAG_W-1:0]      tag_t;
    typedef logic [WIDX_W-1:0]     widx_t;
    typedef logic [LINE_BYTES-1:0] mask_t;
    typedef logic [LINE_BITS-1:0]  line_data_t;
    typedef logic [HPTR_W-1:0]     hptr_t;

    // one offered store
    typedef struct packed {
        addr_t addr;
        data_t data;
        be_t   be;
    } store_t;

    // one word write as it appears on the bus
    typedef struct packed {
        addr_t addr;
        data_t data;
        be_t   be;
    } bus_word_t;

    // result of a search for the next word holding valid bytes
    typedef struct packed {
        logic  found;
        widx_t idx;
    } wsel_t;

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic widx_t widx_of(input addr_t a);
        return a[OFF_W-1:LANE_W];
    endfunction

    // lowest word index at or above 'from' with any valid byte
    function automatic wsel_t find_word(input mask_t m, input int from);
        wsel_t r;
        r = '0;
        for (int w = WORDS - 1; w >= 0; w--) begin
            if (w >= from && (|m[w*BE_W +: BE_W])) begin
                r.found = 1'b1;
                r.idx   = widx_t'(w);
            end
        end
        return r;
    endfunction

    function automatic bus_word_t make_word(input tag_t t, input widx_t idx,
                                            input line_data_t d, input mask_t m);
        bus_word_t r;
        r.addr = {t, idx, {LANE_W{1'b0}}};
        r.data = d[int'(idx)*DATA_W +: DATA_W];
        r.be   = m[int'(idx)*BE_W +: BE_W];
        return r;
    endfunction

endpackage

// File: rtl/wb_entry.sv
module wb_entry
    import wbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       alloc,
    input  logic       merge,
    input  store_t     st,
    input  logic       start,
    input  logic       retire,
    output logic       valid,
    output logic       draining,
    output tag_t       tag,
    output mask_t      mask,
    output line_data_t data
);

    mask_t      nxt_mask;
    line_data_t nxt_data;
    widx_t      w;

    // byte-lane write of the offered store into the line image
    always_comb begin
        w        = widx_of(st.addr);
        nxt_mask = alloc ? '0 : mask;
        nxt_data = alloc ? '0 : data;
        for (int b = 0; b < BE_W; b++) begin
            if (st.be[b]) begin
                nxt_mask[int'(w)*BE_W + b]         = 1'b1;
                nxt_data[(int'(w)*BE_W + b)*8 +: 8] = st.data[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            draining <= 1'b0;
            tag      <= '0;
            mask     <= '0;
            data     <= '0;
        end else begin
            if (alloc) begin
                valid    <= 1'b1;
                draining <= 1'b0;
                tag      <= tag_of(st.addr);
                mask     <= nxt_mask;
                data     <= nxt_data;
            end else if (merge) begin
                mask <= nxt_mask;
                data <= nxt_data;
            end
            if (start) begin
                draining <= 1'b1;
            end
            if (retire) begin
                valid    <= 1'b0;
                draining <= 1'b0;
                mask     <= '0;
            end
        end
    end

endmodule

// File: rtl/wb_ctrl.sv
module wb_ctrl
    import wbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  store_t           st,
    input  logic             flush,
    input  logic [N_ENT-1:0] ent_valid,
    input  logic [N_ENT-1:0] ent_drain,
    input  tag_t             ent_tag [N_ENT],
    input  logic             retire_head,
    output logic             stall,
    output logic [N_ENT-1:0] merge_v,
    output logic [N_ENT-1:0] alloc_v,
    output hptr_t            head
);

    logic [N_ENT-1:0] hit;
    logic             has_bytes;
    logic             full;
    logic             take;
    hptr_t            tail;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            hit[i] = ent_valid[i] && !ent_drain[i] && (ent_tag[i] == tag_of(st.addr));
        end
        has_bytes = |st.be;
        full      = &ent_valid;
        stall     = st_valid && (flush || (has_bytes && !(|hit) && full));
        take      = st_valid && !stall && has_bytes;
        // occupied entries are contiguous from the head, so the tail is head + count
        tail      = head + hptr_t'($countones(ent_valid));
        merge_v   = take ? hit : '0;
        alloc_v   = '0;
        if (take && !(|hit)) begin
            alloc_v[tail] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
        end else if (retire_head) begin
            head <= head + hptr_t'(1);
        end
    end

endmodule

// File: rtl/wb_drain.sv
module wb_drain
    import wbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       head_valid,
    input  logic       head_drain,
    input  logic       head_merge,
    input  tag_t       head_tag,
    input  mask_t      head_mask,
    input  line_data_t head_data,
    input  logic       bus_ack,
    output logic       bus_req,
    output addr_t      bus_addr,
    output data_t      bus_wdata,
    output be_t        bus_be,
    output logic       start,
    output logic       retire
);

    logic      req_q;
    bus_word_t word_q;
    widx_t     cur_q;
    wsel_t     first_w;
    wsel_t     next_w;
    logic      adv;

    always_comb begin
        first_w = find_word(head_mask, 0);
        next_w  = find_word(head_mask, int'(cur_q) + 1);
        // a merge into the head this cycle defers the start by one cycle
        start   = !req_q && head_valid && !head_drain && !head_merge && first_w.found;
        adv     = req_q && bus_ack;
        retire  = adv && !next_w.found;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            word_q <= '0;
            cur_q  <= '0;
        end else if (start) begin
            req_q  <= 1'b1;
            word_q <= make_word(head_tag, first_w.idx, head_data, head_mask);
            cur_q  <= first_w.idx;
        end else if (adv) begin
            if (next_w.found) begin
                word_q <= make_word(head_tag, next_w.idx, head_data, head_mask);
                cur_q  <= next_w.idx;
            end else begin
                req_q <= 1'b0;
            end
        end
    end

    assign bus_req   = req_q;
    assign bus_addr  = word_q.addr;
    assign bus_wdata = word_q.data;
    assign bus_be    = word_q.be;

endmodule

// File: rtl/store_wbuf.sv
module store_wbuf
    import wbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              st_stall,
    input  logic              flush,
    output logic              wb_empty,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [BE_W-1:0]   bus_be,
    input  logic              bus_ack
);

    store_t           st;
    logic [N_ENT-1:0] ent_valid;
    logic [N_ENT-1:0] ent_drain;
    tag_t             ent_tag  [N_ENT];
    mask_t            ent_mask [N_ENT];
    line_data_t       ent_data [N_ENT];
    logic [N_ENT-1:0] merge_v;
    logic [N_ENT-1:0] alloc_v;
    logic [N_ENT-1:0] start_v;
    logic [N_ENT-1:0] retire_v;
    hptr_t            head;
    logic             drain_start;
    logic             drain_retire;

    assign st = '{addr: st_addr, data: st_data, be: st_be};

    wb_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .st_valid    (st_valid),
        .st          (st),
        .flush       (flush),
        .ent_valid   (ent_valid),
        .ent_drain   (ent_drain),
        .ent_tag     (ent_tag),
        .retire_head (drain_retire),
        .stall       (st_stall),
        .merge_v     (merge_v),
        .alloc_v     (alloc_v),
        .head        (head)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign start_v[i]  = drain_start  && (head == hptr_t'(i));
        assign retire_v[i] = drain_retire && (head == hptr_t'(i));

        wb_entry u_entry (
            .clk      (clk),
            .rst      (rst),
            .alloc    (alloc_v[i]),
            .merge    (merge_v[i]),
            .st       (st),
            .start    (start_v[i]),
            .retire   (retire_v[i]),
            .valid    (ent_valid[i]),
            .draining (ent_drain[i]),
            .tag      (ent_tag[i]),
            .mask     (ent_mask[i]),
            .data     (ent_data[i])
        );
    end

    wb_drain u_drain (
        .clk        (clk),
        .rst        (rst),
        .head_valid (ent_valid[head]),
        .head_drain (ent_drain[head]),
        .head_merge (merge_v[head]),
        .head_tag   (ent_tag[head]),
        .head_mask  (ent_mask[head]),
        .head_data  (ent_data[head]),
        .bus_ack    (bus_ack),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .start      (drain_start),
        .retire     (drain_retire)
    );

    assign wb_empty = ~|ent_valid;

endmodule

// File: rtl/store_wbuf_chk.sv
module store_wbuf_chk
    import wbuf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             st_valid,
    input logic             st_stall,
    input logic             flush,
    input logic             wb_empty,
    input logic             bus_req,
    input logic             bus_ack,
    input addr_t            bus_addr,
    input data_t            bus_wdata,
    input be_t              bus_be,
    input logic [N_ENT-1:0] ent_valid,
    input logic [N_ENT-1:0] ent_drain,
    input tag_t             ent_tag [N_ENT],
    input hptr_t            head
);

    // R5: a pending word holds until it is taken
    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_be)));

    // R3: after a taken word the next one is higher in the same line, or the bus goes idle
    a_r3_ascending_words: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> (!bus_req ||
            ((bus_addr[ADDR_W-1:OFF_W] == $past(bus_addr[ADDR_W-1:OFF_W])) &&
             (bus_addr[OFF_W-1:LANE_W] > $past(bus_addr[OFF_W-1:LANE_W])))));

    // R3: presented words are aligned and carry at least one byte
    a_r3_word_shape: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ((bus_addr[LANE_W-1:0] == '0) && (bus_be != '0)));

    // R8: an empty buffer presents nothing
    a_r8_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
        wb_empty |-> !bus_req);

    // R7: an empty buffer never refuses a store outside flush
    a_r7_no_stall_when_empty: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !flush && wb_empty) |-> !st_stall);

    // R4: the oldest pointer always names a held entry when any is held
    a_r4_head_is_oldest: assert property (@(posedge clk) disable iff (rst)
        (|ent_valid) |-> ent_valid[head]);

    // R6: only one entry drains at a time, and it is the oldest
    a_r6_single_drainer: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ent_drain) && ((ent_drain == '0) || ent_drain[head]));

    // R2: no two open entries hold the same line
    for (genvar i = 0; i < N_ENT; i++) begin : g_pi
        for (genvar j = i + 1; j < N_ENT; j++) begin : g_pj
            a_r2_one_open_per_line: assert property (@(posedge clk) disable iff (rst)
                (ent_valid[i] && ent_valid[j] && !ent_drain[i] && !ent_drain[j]) |->
                    (ent_tag[i] != ent_tag[j]));
        end
    end

endmodule

bind store_wbuf store_wbuf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_stall  (st_stall),
    .flush     (flush),
    .wb_empty  (wb_empty),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .ent_valid (ent_valid),
    .ent_drain (ent_drain),
    .ent_tag   (ent_tag),
    .head      (head)
);

// File: tb/store_wbuf_bench.sv
`timescale 1ns/1ps
module store_wbuf_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_stall;
    logic        flush = 1'b0;
    logic        wb_empty;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ack;

    always #2.5 clk = ~clk;

    store_wbuf u_store_wbuf (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall), .flush(flush), .wb_empty(wb_empty),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_ack(bus_ack)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // bus responder and write log
    int          lat = 0;
    int          wcnt = 0;
    int          hold_err = 0;
    int          log_n = 0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [3:0]  log_be   [64];
    int          log_edge [64];
    logic        pend = 1'b0;
    logic [31:0] p_addr, p_data;
    logic [3:0]  p_be;

    initial begin
        bus_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (pend && (!bus_req || bus_addr != p_addr || bus_wdata != p_data || bus_be != p_be))
                hold_err++;
            if (bus_req && wcnt >= lat) begin
                bus_ack = 1'b1;
                if (log_n < 64) begin
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_wdata;
                    log_be[log_n]   = bus_be;
                    log_edge[log_n] = cyc + 1;
                end
                log_n++;
                wcnt = 0;
                pend = 1'b0;
            end else begin
                bus_ack = 1'b0;
                pend    = bus_req;
                p_addr  = bus_addr;
                p_data  = bus_wdata;
                p_be    = bus_be;
                if (bus_req) wcnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // starts and ends just after a falling edge
    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                            output int stall_n, output int acc_edge);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        stall_n = 0;
        #1;
        while (st_stall) begin
            stall_n++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        acc_edge = cyc;
        st_valid = 1'b0;
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 3000; k++) begin
            if (wb_empty && !bus_req) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_word(input int k, input string req, input logic [31:0] a,
                              input logic [31:0] d, input logic [3:0] be);
        logic [31:0] m;
        m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        check(log_addr[k] == a, req, "word address", log_addr[k], a);
        check(log_be[k] == be, req, "word byte enables", {28'd0, log_be[k]}, {28'd0, be});
        check((log_data[k] & m) == (d & m), req, "word data", log_data[k] & m, d & m);
    endtask

    task automatic t_reset();
        check(bus_req == 1'b0, "R1", "bus_req in reset", {31'd0, bus_req}, 32'd0);
        check(wb_empty == 1'b1, "R1", "wb_empty in reset", {31'd0, wb_empty}, 32'd1);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(bus_req == 1'b0, "R1", "bus_req after reset", {31'd0, bus_req}, 32'd0);
        check(wb_empty == 1'b1, "R1", "wb_empty after reset", {31'd0, wb_empty}, 32'd1);
        check(st_stall == 1'b0, "R1", "st_stall after reset", {31'd0, st_stall}, 32'd0);
    endtask

    task automatic t_merge();
        int s, e;
        lat = 12; log_n = 0;
        do_store(32'h0000_1000, 32'h1111_1111, 4'b1111, s, e);
        do_store(32'h0000_2008, 32'hAABB_CCDD, 4'b1111, s, e);
        do_store(32'h0000_2008, 32'h0000_EE00, 4'b0010, s, e);
        do_store(32'h0000_2000, 32'h7700_0000, 4'b1000, s, e);
        wait_empty();
        check(log_n == 3, "R2", "merged word count", log_n, 3);
        check_word(0, "R2", 32'h0000_1000, 32'h1111_1111, 4'b1111);
        check_word(1, "R3", 32'h0000_2000, 32'h7700_0000, 4'b1000);
        check_word(2, "R2", 32'h0000_2008, 32'hAABB_EEDD, 4'b1111);
    endtask

    task automatic t_ascending();
        int s, e;
        lat = 0; log_n = 0;
        do_store(32'h0001_000C, 32'h3333_3333, 4'b1111, s, e);
        do_store(32'h0001_0004, 32'h1111_1111, 4'b0011, s, e);
        do_store(32'h0001_0008, 32'h2222_2222, 4'b1111, s, e);
        do_store(32'h0001_0000, 32'h0000_0000, 4'b1111, s, e);
        wait_empty();
        check(log_n == 4, "R3", "word count", log_n, 4);
        check_word(0, "R3", 32'h0001_0000, 32'h0, 4'b1111);
        check_word(1, "R3", 32'h0001_0004, 32'h1111_1111, 4'b0011);
        check_word(2, "R3", 32'h0001_0008, 32'h2222_2222, 4'b1111);
        check_word(3, "R3", 32'h0001_000C, 32'h3333_3333, 4'b1111);
        check(log_edge[1] == log_edge[0] + 1 && log_edge[3] == log_edge[2] + 1, "R5",
              "back-to-back words", log_edge[1] - log_edge[0], 1);
    endtask

    task automatic t_order();
        int s, e;
        lat = 2; log_n = 0;
        do_store(32'h0000_4000, 32'hA0A0_A0A0, 4'b1111, s, e);
        do_store(32'h0000_5004, 32'hB1B1_B1B1, 4'b1111, s, e);
        do_store(32'h0000_500C, 32'hB3B3_B3B3, 4'b1111, s, e);
        wait_empty();
        check(log_n == 3, "R4", "word count", log_n, 3);
        check_word(0, "R4", 32'h0000_4000, 32'hA0A0_A0A0, 4'b1111);
        check_word(1, "R4", 32'h0000_5004, 32'hB1B1_B1B1, 4'b1111);
        check_word(2, "R4", 32'h0000_500C, 32'hB3B3_B3B3, 4'b1111);
        check(log_edge[1] >= log_edge[0] + 2, "R4", "idle gap between entries",
              log_edge[1] - log_edge[0], 2);
    endtask

    task automatic t_no_merge_draining();
        int s, e;
        lat = 6; log_n = 0;
        do_store(32'h0000_3004, 32'h1234_5678, 4'b1111, s, e);
        while (!bus_req) @(negedge clk);
        do_store(32'h0000_3004, 32'h9ABC_DEF0, 4'b1111, s, e);
        wait_empty();
        check(log_n == 2, "R6", "separate entry after drain start", log_n, 2);
        check_word(0, "R6", 32'h0000_3004, 32'h1234_5678, 4'b1111);
        check_word(1, "R6", 32'h0000_3004, 32'h9ABC_DEF0, 4'b1111);
    endtask

    task automatic t_stall();
        int s, e;
        lat = 8; log_n = 0;
        do_store(32'h0000_6000, 32'h6666_6666, 4'b1111, s, e);
        do_store(32'h0000_7000, 32'h7070_7070, 4'b1111, s, e);
        do_store(32'h0000_7004, 32'h7474_7474, 4'b1111, s, e);
        check(s == 0, "R7", "merge while full does not stall", s, 0);
        do_store(32'h0000_8000, 32'h8888_8888, 4'b1111, s, e);
        check(s > 0, "R7", "new line while full stalls", s, 1);
        check(e == log_edge[0] + 1, "R8", "accept edge after last ack", e, log_edge[0] + 1);
        wait_empty();
        check(log_n == 4, "R7", "word count", log_n, 4);
        check_word(3, "R7", 32'h0000_8000, 32'h8888_8888, 4'b1111);
    endtask

    task automatic t_free_timing();
        int s, e, seen;
        lat = 0; log_n = 0; seen = -1;
        do_store(32'h0000_9000, 32'h0000_0055, 4'b0001, s, e);
        for (int k = 0; k < 20; k++) begin
            if (wb_empty && seen < 0) seen = cyc;
            @(negedge clk);
        end
        check(log_n == 1, "R8", "word count", log_n, 1);
        check(seen == log_edge[0], "R8", "wb_empty edge", seen, log_edge[0]);
    endtask

    task automatic t_start_delay();
        int s, e;
        lat = 0; log_n = 0;
        do_store(32'h0000_A000, 32'hAAAA_AAAA, 4'b1111, s, e);
        check(bus_req == 1'b0, "R9", "no request after accept edge", {31'd0, bus_req}, 32'd0);
        @(negedge clk);
        check(bus_req == 1'b1, "R9", "request after second edge", {31'd0, bus_req}, 32'd1);
        wait_empty();
        log_n = 0;
        do_store(32'h0000_B000, 32'hB0B0_B0B0, 4'b1111, s, e);
        do_store(32'h0000_B004, 32'hB4B4_B4B4, 4'b1111, s, e);
        check(bus_req == 1'b0, "R9", "merge defers drain", {31'd0, bus_req}, 32'd0);
        @(negedge clk);
        check(bus_req == 1'b1, "R9", "drain one cycle later", {31'd0, bus_req}, 32'd1);
        wait_empty();
        check(log_n == 2, "R9", "merged words", log_n, 2);
        check_word(1, "R9", 32'h0000_B004, 32'hB4B4_B4B4, 4'b1111);
    endtask

    task automatic t_flush();
        int s, e, stalled;
        lat = 3; log_n = 0; stalled = 1;
        do_store(32'h0000_C000, 32'hC0C0_C0C0, 4'b1111, s, e);
        do_store(32'h0000_D000, 32'hD0D0_D0D0, 4'b1111, s, e);
        flush = 1'b1;
        st_valid = 1'b1; st_addr = 32'h0000_D004; st_data = 32'hDEAD_BEEF; st_be = 4'b1111;
        for (int k = 0; k < 200; k++) begin
            #1;
            if (!st_stall) stalled = 0;
            if (wb_empty) break;
            @(negedge clk);
        end
        check(stalled == 1, "R10", "stall held through flush", stalled, 1);
        check(wb_empty == 1'b1, "R10", "empty reached during flush", {31'd0, wb_empty}, 32'd1);
        st_valid = 1'b0; flush = 1'b0;
        @(negedge clk);
        wait_empty();
        check(log_n == 2, "R10", "only held words written", log_n, 2);
        check_word(1, "R10", 32'h0000_D000, 32'hD0D0_D0D0, 4'b1111);
    endtask

    task automatic t_no_bytes();
        int s, e;
        lat = 0; log_n = 0;
        do_store(32'h0000_F000, 32'hFFFF_FFFF, 4'b0000, s, e);
        check(s == 0, "R11", "empty-enable store not stalled", s, 0);
        repeat (6) @(negedge clk);
        check(log_n == 0, "R11", "no bus write", log_n, 0);
        check(wb_empty == 1'b1, "R11", "buffer still empty", {31'd0, wb_empty}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_merge();
        t_ascending();
        t_order();
        t_no_merge_draining();
        t_stall();
        t_free_timing();
        t_start_delay();
        t_flush();
        t_no_bytes();
        check(hold_err == 0, "R5", "bus outputs held until ack", hold_err, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
        summary();
        $finish;
    end

endmodule